// File: doc/BRIEF.md
# Synchronous Rectified Sample Accumulator

This block demodulates one channel of a resolver-style sensor. It takes a stream of signed converter samples and a rectify reference. The reference is chosen from one of four phases of the excitation square wave, an external level, or that external level inverted. While the reference is high each sample is added, and while it is low each sample is subtracted. The sum over a programmable number of whole reference periods is therefore proportional to the amplitude of the component that is in phase with the reference.

At the end of every window the block publishes several values. These are the accumulated value shifted right logically, a timestamp taken at the start, centre or end of the window, and high and low flags from a threshold window check. It also publishes four sample counters: the samples taken in each half of the reference, and the samples whose sign disagrees with that half. Optionally, windows that contain any sign disagreement are dropped. Independent of the windows, the block tracks the largest and smallest sample seen. Each of these two registers can be cleared to zero.

Top module: `sync_rect_accum`

## Requirements
- R1: `ref_sel` picks the rectify reference. Codes 0 to 3 pick `exc_phase[0]` to `exc_phase[3]`, code 4 picks `ext_ref`, code 5 picks the inverse of `ext_ref`, and codes 6 and 7 act as code 0.
- R2: Only cycles with `smp_vld` high count as samples. A rising edge is a valid sample with reference high whose previous valid sample had reference low. After reset the previous reference is taken as high. The first window opens at the first rising edge. A window spans `win_len`+1 reference periods and closes at the rising edge that ends them. That closing sample is excluded from the old window and opens the next one.
- R3: Within a window, a sample taken with reference high is added and a sample taken with reference low is subtracted. `res_acc` is the AW-bit sum shifted right by `res_shift`, with zeros entering from the top.
- R4: `win_len` is captured when a window opens. A change during a window takes effect from the next window.
- R5: `res_vld` is high for exactly one cycle, one clock after the closing sample. All result outputs keep their values until the next accepted window.
- R6: `ts_sel` picks the timestamp. Code 0 gives the end (`tstamp_in` at the closing sample) and code 1 gives the start (`tstamp_in` at the opening sample). Code 2 gives the centre, computed as start + ((end - start) >> 1) modulo 2^TW. Code 3 acts as code 0.
- R7: `cnt_pos` and `cnt_neg` give the number of samples the window took with reference high and with reference low.
- R8: `mis_pos` counts negative samples taken with reference high. `mis_neg` counts positive samples taken with reference low. A zero sample counts in neither.
- R9: `ovf_hi` is set when `res_acc` > `amp_hi`, and `ovf_lo` is set when `res_acc` < `amp_lo`. Both comparisons are unsigned, and both flags update together with `res_acc`.
- R10: When `drop_bad` is high, a window with a nonzero mismatch count gives no `res_vld` pulse and leaves every result output unchanged.
- R11: `smp_max` and `smp_min` hold the signed maximum and minimum of valid samples since the last reset or clear. Both reset to 0.
- R12: `clr_max` (`clr_min`) forces `smp_max` (`smp_min`) to 0 on the next clock, taking priority over a sample in the same cycle.
- R13: During and right after reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample strobe |
| smp_data | input | DW | Signed sample |
| exc_phase | input | 4 | Excitation square wave at 0/90/180/270 degrees |
| ext_ref | input | 1 | External rectify level |
| ref_sel | input | 3 | Reference select code (R1) |
| win_len | input | LW | Window length in periods minus one |
| ts_sel | input | 2 | Timestamp position code (R6) |
| res_shift | input | SW | Logical right shift of the sum |
| drop_bad | input | 1 | Drop windows with sign mismatches |
| amp_hi | input | AW | Upper amplitude threshold |
| amp_lo | input | AW | Lower amplitude threshold |
| clr_max | input | 1 | Clear maximum register |
| clr_min | input | 1 | Clear minimum register |
| tstamp_in | input | TW | Time base |
| res_vld | output | 1 | Result pulse |
| res_acc | output | AW | Shifted accumulated value |
| res_ts | output | TW | Window timestamp |
| ovf_hi | output | 1 | Result above upper threshold |
| ovf_lo | output | 1 | Result below lower threshold |
| cnt_pos | output | CW | Samples in high half |
| cnt_neg | output | CW | Samples in low half |
| mis_pos | output | CW | Negative samples in high half |
| mis_neg | output | CW | Positive samples in low half |
| smp_max | output | DW | Running signed maximum |
| smp_min | output | DW | Running signed minimum |

## Verification
Every window result, including its flags, counters and timestamp, appears exactly one clock after the valid sample that closes the window. Changes to the maximum and minimum appear one clock after the sample or clear that causes them. The bench applies each input just after a falling edge and reads the outputs at the next falling edge. Each read therefore shows the effect of exactly one sample. Window results are compared only on the read that follows a closing sample. Any pulse outside those reads is caught by a per-run count of pulses.

// File: rtl/rsa_pkg.sv
package rsa_pkg;
  typedef enum logic [2:0] {
    REF_PH0   = 3'd0,
    REF_PH90  = 3'd1,
    REF_PH180 = 3'd2,
    REF_PH270 = 3'd3,
    REF_EXT   = 3'd4,
    REF_EXT_N = 3'd5
  } ref_code_e;

  typedef enum logic [1:0] {
    TS_END   = 2'd0,
    TS_START = 2'd1,
    TS_MID   = 2'd2
  } ts_code_e;
endpackage

// File: rtl/rsa_ref_sel.sv
module rsa_ref_sel
  import rsa_pkg::*;
(
  input  logic [3:0] exc_phase,
  input  logic       ext_ref,
  input  logic [2:0] ref_sel,
  output logic       ref_o
);
  always_comb begin
    case (ref_code_e'(ref_sel))
      REF_PH90:  ref_o = exc_phase[1];
      REF_PH180: ref_o = exc_phase[2];
      REF_PH270: ref_o = exc_phase[3];
      REF_EXT:   ref_o = ext_ref;
      REF_EXT_N: ref_o = !ext_ref;
      default:   ref_o = exc_phase[0];
    endcase
  end
endmodule

// File: rtl/rsa_extrema.sv
module rsa_extrema #(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vld_i,
  input  logic signed [DW-1:0] data_i,
  input  logic                 clr_max_i,
  input  logic                 clr_min_i,
  output logic signed [DW-1:0] max_o,
  output logic signed [DW-1:0] min_o
);
  logic signed [DW-1:0] max_q, max_d, min_q, min_d;

  always_comb begin
    max_d = max_q;
    min_d = min_q;
    if (clr_max_i)                     max_d = '0;
    else if (vld_i && data_i > max_q)  max_d = data_i;
    if (clr_min_i)                     min_d = '0;
    else if (vld_i && data_i < min_q)  min_d = data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_q <= '0;
      min_q <= '0;
    end else begin
      max_q <= max_d;
      min_q <= min_d;
    end
  end

  assign max_o = max_q;
  assign min_o = min_q;

  // R12: a clear request lands as zero on the following clock
  assert_clear_max_R12: assert property (@(posedge clk) disable iff (!rst_n)
    clr_max_i |=> (max_o == '0));
  assert_clear_min_R12: assert property (@(posedge clk) disable iff (!rst_n)
    clr_min_i |=> (min_o == '0));
  // R11: after a sample the maximum is never below it, the minimum never above it
  assert_max_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && !clr_max_i) |=> (max_o >= $past(data_i)));
  assert_min_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && !clr_min_i) |=> (min_o <= $past(data_i)));
endmodule

// File: rtl/rsa_window.sv
module rsa_window #(
  parameter int DW = 16,
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int LW = 8,
  parameter int TW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vld_i,
  input  logic signed [DW-1:0] data_i,
  input  logic                 ref_i,
  input  logic [LW-1:0]        win_len_i,
  input  logic [TW-1:0]        tstamp_i,
  output logic                 close_o,
  output logic signed [AW-1:0] acc_o,
  output logic [CW-1:0]        cpos_o,
  output logic [CW-1:0]        cneg_o,
  output logic [CW-1:0]        mpos_o,
  output logic [CW-1:0]        mneg_o,
  output logic [TW-1:0]        tstart_o
);
  logic                 prev_q, prev_d, run_q, run_d;
  logic [LW-1:0]        per_q, per_d, len_q, len_d;
  logic signed [AW-1:0] acc_q, acc_d, smp_ext, contrib;
  logic [CW-1:0]        cpos_q, cpos_d, cneg_q, cneg_d;
  logic [CW-1:0]        mpos_q, mpos_d, mneg_q, mneg_d;
  logic [TW-1:0]        tst_q, tst_d;
  logic                 rise, close, open, mis_p, mis_n;

  assign smp_ext = AW'(data_i);
  assign contrib = ref_i ? smp_ext : -smp_ext;
  assign mis_p   = ref_i && data_i[DW-1];
  assign mis_n   = !ref_i && !data_i[DW-1] && (data_i != '0);
  assign rise    = vld_i && ref_i && !prev_q;
  assign close   = rise && run_q && (per_q == len_q);
  assign open    = rise && (!run_q || close);

  always_comb begin
    prev_d = prev_q;  run_d  = run_q;  per_d  = per_q;  len_d  = len_q;
    acc_d  = acc_q;   cpos_d = cpos_q; cneg_d = cneg_q;
    mpos_d = mpos_q;  mneg_d = mneg_q; tst_d  = tst_q;
    if (vld_i) prev_d = ref_i;
    if (open) begin
      run_d  = 1'b1;
      per_d  = '0;
      len_d  = win_len_i;
      acc_d  = contrib;
      cpos_d = CW'(1);
      cneg_d = '0;
      mpos_d = mis_p ? CW'(1) : '0;
      mneg_d = '0;
      tst_d  = tstamp_i;
    end else if (vld_i && run_q) begin
      acc_d = acc_q + contrib;
      if (ref_i) cpos_d = cpos_q + CW'(1);
      else       cneg_d = cneg_q + CW'(1);
      if (mis_p) mpos_d = mpos_q + CW'(1);
      if (mis_n) mneg_d = mneg_q + CW'(1);
      if (rise)  per_d  = per_q + LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1; run_q  <= 1'b0; per_q  <= '0; len_q  <= '0;
      acc_q  <= '0;   cpos_q <= '0;   cneg_q <= '0;
      mpos_q <= '0;   mneg_q <= '0;   tst_q  <= '0;
    end else begin
      prev_q <= prev_d; run_q  <= run_d;  per_q  <= per_d;  len_q  <= len_d;
      acc_q  <= acc_d;  cpos_q <= cpos_d; cneg_q <= cneg_d;
      mpos_q <= mpos_d; mneg_q <= mneg_d; tst_q  <= tst_d;
    end
  end

  assign close_o  = close;
  assign acc_o    = acc_q;
  assign cpos_o   = cpos_q;
  assign cneg_o   = cneg_q;
  assign mpos_o   = mpos_q;
  assign mneg_o   = mneg_q;
  assign tstart_o = tst_q;

  // R2: the period count of an open window never passes its captured length
  assert_period_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (per_q <= len_q));
  // R2: a window that closes is immediately replaced by a running one
  assert_back_to_back_R2: assert property (@(posedge clk) disable iff (!rst_n)
    close |=> (run_q && per_q == '0));
endmodule

// File: rtl/sync_rect_accum.sv
module sync_rect_accum
  import rsa_pkg::*;
#(
  parameter  int DW = 16,
  parameter  int AW = 32,
  parameter  int CW = 16,
  parameter  int LW = 8,
  parameter  int TW = 16,
  localparam int SW = $clog2(AW)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_vld,
  input  logic signed [DW-1:0] smp_data,
  input  logic [3:0]           exc_phase,
  input  logic                 ext_ref,
  input  logic [2:0]           ref_sel,
  input  logic [LW-1:0]        win_len,
  input  logic [1:0]           ts_sel,
  input  logic [SW-1:0]        res_shift,
  input  logic                 drop_bad,
  input  logic [AW-1:0]        amp_hi,
  input  logic [AW-1:0]        amp_lo,
  input  logic                 clr_max,
  input  logic                 clr_min,
  input  logic [TW-1:0]        tstamp_in,
  output logic                 res_vld,
  output logic [AW-1:0]        res_acc,
  output logic [TW-1:0]        res_ts,
  output logic                 ovf_hi,
  output logic                 ovf_lo,
  output logic [CW-1:0]        cnt_pos,
  output logic [CW-1:0]        cnt_neg,
  output logic [CW-1:0]        mis_pos,
  output logic [CW-1:0]        mis_neg,
  output logic signed [DW-1:0] smp_max,
  output logic signed [DW-1:0] smp_min
);
  logic                 ref_now, w_close, accept, cap;
  logic signed [AW-1:0] w_acc;
  logic [CW-1:0]        w_cpos, w_cneg, w_mpos, w_mneg;
  logic [TW-1:0]        w_tstart, ts_span, ts_pick;
  logic [AW-1:0]        shifted;

  rsa_ref_sel u_ref (
    .exc_phase (exc_phase),
    .ext_ref   (ext_ref),
    .ref_sel   (ref_sel),
    .ref_o     (ref_now)
  );

  rsa_window #(.DW(DW), .AW(AW), .CW(CW), .LW(LW), .TW(TW)) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .vld_i     (smp_vld),
    .data_i    (smp_data),
    .ref_i     (ref_now),
    .win_len_i (win_len),
    .tstamp_i  (tstamp_in),
    .close_o   (w_close),
    .acc_o     (w_acc),
    .cpos_o    (w_cpos),
    .cneg_o    (w_cneg),
    .mpos_o    (w_mpos),
    .mneg_o    (w_mneg),
    .tstart_o  (w_tstart)
  );

  rsa_extrema #(.DW(DW)) u_ext (
    .clk       (clk),
    .rst_n     (rst_n),
    .vld_i     (smp_vld),
    .data_i    (smp_data),
    .clr_max_i (clr_max),
    .clr_min_i (clr_min),
    .max_o     (smp_max),
    .min_o     (smp_min)
  );

  // result stage: shift, window check, timestamp pick
  assign shifted = $unsigned(w_acc) >> res_shift;
  assign ts_span = tstamp_in - w_tstart;
  assign accept  = !(drop_bad && ((w_mpos != '0) || (w_mneg != '0)));
  assign cap     = w_close && accept;

  always_comb begin
    case (ts_code_e'(ts_sel))
      TS_START: ts_pick = w_tstart;
      TS_MID:   ts_pick = w_tstart + (ts_span >> 1);
      default:  ts_pick = tstamp_in;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld <= 1'b0;
      res_acc <= '0;  res_ts  <= '0;
      ovf_hi  <= 1'b0; ovf_lo <= 1'b0;
      cnt_pos <= '0;  cnt_neg <= '0;
      mis_pos <= '0;  mis_neg <= '0;
    end else begin
      res_vld <= cap;
      if (cap) begin
        res_acc <= shifted;
        res_ts  <= ts_pick;
        ovf_hi  <= shifted > amp_hi;
        ovf_lo  <= shifted < amp_lo;
        cnt_pos <= w_cpos;
        cnt_neg <= w_cneg;
        mis_pos <= w_mpos;
        mis_neg <= w_mneg;
      end
    end
  end

  // R5: pulses are isolated and the result holds between them
  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |=> !res_vld);
  assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld |-> $stable(res_acc));
  // R8: mismatches in a half can never outnumber the samples of that half
  assert_mismatch_le_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mis_pos <= cnt_pos) && (mis_neg <= cnt_neg));
  // R10: a corrupt window with dropping on gives no pulse
  assert_drop_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (w_close && drop_bad && ((w_mpos != '0) || (w_mneg != '0))) |=> !res_vld);
endmodule

// File: tb/sync_rect_accum_tb_top.sv
module sync_rect_accum_tb_top;
  typedef struct packed {
    logic [2:0]  sel;
    logic [7:0]  h;
    logic [15:0] a;
    logic [7:0]  len;
    logic [4:0]  sh;
    logic [1:0]  ts;
    logic [3:0]  nwin;
    logic        inv;
    logic        gap;
    logic        drop;
    logic        pre;
    logic [31:0] hi;
    logic [31:0] lo;
  } vec_t;

  // sel h a len sh ts nwin inv gap drop pre hi lo
  localparam vec_t VEC [0:8] = '{
    '{3'd0, 8'd4, 16'd100,  8'd0, 5'd0, 2'd0, 4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 32'd1000, 32'd0},
    '{3'd1, 8'd3, 16'd50,   8'd2, 5'd1, 2'd1, 4'd2, 1'b0, 1'b1, 1'b0, 1'b0, 32'd100,  32'd0},
    '{3'd2, 8'd2, 16'd1000, 8'd1, 5'd2, 2'd2, 4'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'd5000, 32'd3000},
    '{3'd3, 8'd5, 16'd7,    8'd3, 5'd0, 2'd2, 4'd1, 1'b0, 1'b0, 1'b0, 1'b0, 32'd1000, 32'd0},
    '{3'd4, 8'd2, 16'd300,  8'd0, 5'd0, 2'd0, 4'd2, 1'b0, 1'b0, 1'b0, 1'b1, 32'd5000, 32'd0},
    '{3'd5, 8'd3, 16'd20,   8'd1, 5'd3, 2'd1, 4'd2, 1'b0, 1'b1, 1'b0, 1'b0, 32'd1000, 32'd0},
    '{3'd6, 8'd2, 16'd9,    8'd0, 5'd0, 2'd3, 4'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'd1000, 32'd0},
    '{3'd0, 8'd2, 16'd10,   8'd1, 5'd4, 2'd0, 4'd2, 1'b1, 1'b0, 1'b0, 1'b0, 32'd0,    32'd0},
    '{3'd0, 8'd2, 16'd10,   8'd0, 5'd0, 2'd0, 4'd2, 1'b1, 1'b0, 1'b1, 1'b0, 32'd0,    32'd0}
  };

  logic clk, rst_n, smp_vld, ext_ref, drop_bad, clr_max, clr_min;
  logic signed [15:0] smp_data;
  logic [3:0]  exc_phase;
  logic [2:0]  ref_sel;
  logic [7:0]  win_len;
  logic [1:0]  ts_sel;
  logic [4:0]  res_shift;
  logic [31:0] amp_hi, amp_lo;
  logic [15:0] tstamp_in;
  logic        res_vld, ovf_hi, ovf_lo;
  logic [31:0] res_acc;
  logic [15:0] res_ts, cnt_pos, cnt_neg, mis_pos, mis_neg;
  logic signed [15:0] smp_max, smp_min;

  int nchk = 0, nfail = 0;
  int k, pulses, per, open0;
  vec_t cv;

  sync_rect_accum dut_i (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
    .exc_phase(exc_phase), .ext_ref(ext_ref), .ref_sel(ref_sel),
    .win_len(win_len), .ts_sel(ts_sel), .res_shift(res_shift),
    .drop_bad(drop_bad), .amp_hi(amp_hi), .amp_lo(amp_lo),
    .clr_max(clr_max), .clr_min(clr_min), .tstamp_in(tstamp_in),
    .res_vld(res_vld), .res_acc(res_acc), .res_ts(res_ts),
    .ovf_hi(ovf_hi), .ovf_lo(ovf_lo), .cnt_pos(cnt_pos), .cnt_neg(cnt_neg),
    .mis_pos(mis_pos), .mis_neg(mis_neg), .smp_max(smp_max), .smp_min(smp_min)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    summary();
  end

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_refs(input logic w);
    int idx;
    if (cv.sel == 3'd4) begin
      exc_phase = {4{~w}}; ext_ref = w;
    end else if (cv.sel == 3'd5) begin
      exc_phase = {4{~w}}; ext_ref = ~w;
    end else begin
      idx = (cv.sel > 3'd5) ? 0 : int'(cv.sel);
      exc_phase = w ? (4'b0001 << idx) : ~(4'b0001 << idx);
      ext_ref = ~w;
    end
  endtask

  task automatic drive(input logic v, input logic w, input logic signed [15:0] d,
                       input logic [15:0] ts);
    smp_vld = v; smp_data = d; tstamp_in = ts;
    set_refs(w);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; smp_vld = 1'b0; clr_max = 1'b0; clr_min = 1'b0;
    smp_data = '0; tstamp_in = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic check_window();
    int j, wn;
    logic [31:0] acc, res;
    logic [15:0] ts_s, ts_e, ts_x;
    wn   = (int'(cv.len) + 1) * int'(cv.h);
    j    = (k - open0) / per;
    acc  = 32'(wn * 2 * int'(cv.a));
    if (cv.inv) acc = -acc;
    res  = acc >> cv.sh;
    ts_s = 16'(7 + 5 * (open0 + (j - 1) * per));
    ts_e = 16'(7 + 5 * (open0 + j * per));
    ts_x = (cv.ts == 2'd1) ? ts_s : (cv.ts == 2'd2) ? 16'(ts_s + 16'(5 * wn)) : ts_e;
    if (cv.drop) begin
      chk("R10 dropped window pulse", longint'(res_vld), 0);
    end else begin
      chk("R5 pulse after closing sample", longint'(res_vld), 1);
      chk("R3 shifted sum", longint'(res_acc), longint'(res));
      chk("R6 timestamp", longint'(res_ts), longint'(ts_x));
      chk("R7 high-half count", longint'(cnt_pos), wn);
      chk("R7 low-half count", longint'(cnt_neg), wn);
      chk("R8 high-half mismatches", longint'(mis_pos), cv.inv ? wn : 0);
      chk("R8 low-half mismatches", longint'(mis_neg), cv.inv ? wn : 0);
      chk("R9 high flag", longint'(ovf_hi), longint'(res > cv.hi));
      chk("R9 low flag", longint'(ovf_lo), longint'(res < cv.lo));
    end
  endtask

  task automatic put(input logic w);
    logic signed [15:0] d;
    d = (w ^ cv.inv) ? $signed(cv.a) : -$signed(cv.a);
    drive(1'b1, w, d, 16'(7 + 5 * k));
    if (res_vld) pulses++;
    if (k > open0 && ((k - open0) % per) == 0) check_window();
    k++;
    if (cv.gap) begin
      drive(1'b0, ~w, 16'sh7FFF, 16'hBEEF);
      if (res_vld) pulses++;
    end
  endtask

  task automatic run_vec(input vec_t v);
    cv = v;
    ref_sel = v.sel; win_len = v.len; ts_sel = v.ts; res_shift = v.sh;
    drop_bad = v.drop; amp_hi = v.hi; amp_lo = v.lo;
    set_refs(1'b0);
    do_reset();
    k = 0; pulses = 0;
    per   = (int'(v.len) + 1) * 2 * int'(v.h);
    open0 = v.pre ? 2 * int'(v.h) : int'(v.h);
    if (v.pre) for (int i = 0; i < int'(v.h); i++) put(1'b1);   // R2: no edge yet
    for (int i = 0; i < int'(v.h); i++) put(1'b0);
    for (int p = 0; p < (int'(v.len) + 1) * int'(v.nwin); p++) begin
      for (int i = 0; i < int'(v.h); i++) put(1'b1);
      for (int i = 0; i < int'(v.h); i++) put(1'b0);
    end
    put(1'b1);
    chk("R2 pulse count", pulses, v.drop ? 0 : int'(v.nwin));
    if (v.drop) begin
      chk("R10 result unchanged", longint'(res_acc), 0);
      chk("R10 counts unchanged", longint'(cnt_pos), 0);
    end
    chk("R11 maximum", longint'(smp_max), int'(v.a));
    chk("R11 minimum", longint'(smp_min), -int'(v.a));
  endtask

  initial begin
    cv = VEC[0];
    ref_sel = '0; win_len = '0; ts_sel = '0; res_shift = '0; drop_bad = 1'b0;
    amp_hi = '0; amp_lo = '0; exc_phase = '0; ext_ref = 1'b0;
    rst_n = 1'b0; smp_vld = 1'b0; clr_max = 1'b0; clr_min = 1'b0;
    smp_data = '0; tstamp_in = '0;
    @(negedge clk);
    // R13: reset state
    chk("R13 res_vld", longint'(res_vld), 0);
    chk("R13 res_acc", longint'(res_acc), 0);
    chk("R13 res_ts", longint'(res_ts), 0);
    chk("R13 flags", longint'({ovf_hi, ovf_lo}), 0);
    chk("R13 counters", longint'(cnt_pos | cnt_neg | mis_pos | mis_neg), 0);
    chk("R13 extrema", longint'(smp_max | smp_min), 0);

    // vector table: R1..R11 across references, shifts, timestamps, gaps
    for (int n = 0; n < 9; n++) run_vec(VEC[n]);

    // R12: clear beats a same-cycle sample; clear minimum alone
    cv = VEC[0]; ref_sel = 3'd0; drop_bad = 1'b0;
    do_reset();
    drive(1'b1, 1'b0, -16'sd40, 16'd0);
    drive(1'b1, 1'b0, 16'sd60, 16'd0);
    clr_max = 1'b1;
    drive(1'b1, 1'b0, 16'sd500, 16'd0);
    clr_max = 1'b0;
    chk("R12 clear max priority", longint'(smp_max), 0);
    chk("R11 min unaffected by max clear", longint'(smp_min), -40);
    drive(1'b1, 1'b0, 16'sd30, 16'd0);
    chk("R11 max after clear", longint'(smp_max), 30);
    clr_min = 1'b1;
    drive(1'b0, 1'b0, 16'sd0, 16'd0);
    clr_min = 1'b0;
    chk("R12 clear min", longint'(smp_min), 0);

    // R4: length change inside a window applies to the next window only
    cv = VEC[0]; cv.a = 16'd10; cv.inv = 1'b0; cv.gap = 1'b0;
    ref_sel = 3'd0; ts_sel = 2'd0; res_shift = '0; win_len = 8'd1;
    do_reset();
    k = 0; pulses = 0;
    for (int i = 0; i < 2; i++) begin drive(1'b1, 1'b0, -16'sd10, 16'(k)); k++; end
    drive(1'b1, 1'b1, 16'sd10, 16'(k)); k++;
    win_len = 8'd0;
    for (int s = 3; s < 15; s++) begin
      logic w;
      w = ((s - 2) % 4) < 2;
      drive(1'b1, w, w ? 16'sd10 : -16'sd10, 16'(k)); k++;
      if (res_vld) pulses++;
      if (s == 10) chk("R4 first window keeps captured length", longint'(res_acc), 80);
      if (s == 14) chk("R4 next window uses new length", longint'(res_acc), 40);
    end
    chk("R4 pulse count", pulses, 2);

    summary();
  end
endmodule